// File: doc/BRIEF.md
# Interleaved Image Stream Selector

This block sits on a byte stream that carries several configuration images woven together. The stream is cut into chunks of a fixed size (288 bytes by default); the first chunk belongs to image 1, the next to image 2, and so on up to the number of images, after which the pattern starts again with image 1. The block keeps only the chunks of one chosen image and passes those bytes on, in order, through a valid/ready output. Bytes of the other images are still taken from the input, but they never reach the output.

While it forwards the chosen image, the block compares that image's first thirteen bytes against a fixed signature. It reports, on two registered flags, that the comparison has finished and whether it matched. A restart pulse captures the image number and the image count, rewinds the chunk position to the start of the stream, empties the output register and clears both flags. Decompression upstream and any parsing of the header beyond the signature are not part of this block.

Top module: `ilv_image_sel`

## Requirements
- R1: Input byte number n (counted from 0 since the last restart or reset, counting every accepted byte) belongs to image ((n / CHUNK_BYTES) mod N) + 1, where N is the captured image count.
- R2: Every accepted byte of the selected image appears on the output exactly once, unchanged and in input order; no byte of any other image appears on the output.
- R3: While the current input position belongs to an image that is not selected, `in_ready_o` is 1 (outside a restart cycle) whatever the value of `out_ready_i`.
- R4: In a cycle with `restart_i` = 1, `in_ready_o` is 0. After that edge the position is byte 0 of the stream, `out_valid_o` is 0, and `hdr_done_o` and `hdr_ok_o` are 0.
- R5: `img_sel_i` and `img_count_i` are captured only at a restart edge; changing them at any other time has no effect on the output. After reset the captured values are image 1 and a count of 1, so every byte is forwarded.
- R6: `hdr_done_o` goes to 1 on the clock edge that accepts the 13th byte of the selected image. At that edge `hdr_ok_o` goes to 1 only if those 13 bytes were, in order, 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 (hex); otherwise it stays 0. `hdr_ok_o` is never 1 while `hdr_done_o` is 0.
- R7: Once `hdr_done_o` is 1, `hdr_done_o` and `hdr_ok_o` keep their values until the next restart or reset.
- R8: While `out_valid_o` = 1 and `out_ready_i` = 0, `out_valid_o` and `out_data_o` hold their values. A byte of the selected image is not accepted while the output register is full and not being drained.
- R9: An `img_count_i` of 0 is captured as 1. A captured image number of 0, or one larger than the captured count, selects nothing: all input is accepted, nothing is output and `hdr_done_o` stays 0.
- R10: After reset `out_valid_o`, `hdr_done_o` and `hdr_ok_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart_i | input | 1 | Rewind the stream and capture the configuration |
| img_sel_i | input | IDX_W (3) | Image number to keep, 1-based |
| img_count_i | input | IDX_W (3) | Number of interleaved images |
| in_valid_i | input | 1 | Input byte is valid |
| in_data_i | input | DATA_W (8) | Input byte |
| in_ready_o | output | 1 | Input byte is taken at the next edge |
| out_valid_o | output | 1 | Output byte is valid |
| out_data_o | output | DATA_W (8) | Output byte |
| out_ready_i | input | 1 | Downstream takes the output byte |
| hdr_done_o | output | 1 | Signature comparison finished |
| hdr_ok_o | output | 1 | Signature matched |

## Verification
The case that needs care is a restart arriving in the very cycle an input byte is offered while the output register is full and stalled. The bench holds `out_ready_i` low so a forwarded byte sits in the output, offers the next byte and raises `restart_i` at once. The restart must win: the offered byte is refused, and on the next cycle the output register and the signature flags are empty. A following stream that picks a different image must then come out aligned from byte 0 of the new position.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // length of the signature at the start of every image
  localparam int SIG_LEN = 13;

  // expected signature byte at a given position of the selected image
  function automatic logic [7:0] sig_byte(input int idx);
    logic [7:0] b;
    case (idx)
      1:             b = 8'h09;
      2, 4, 6, 8:    b = 8'h0F;
      3, 5, 7, 9:    b = 8'hF0;
      12:            b = 8'h01;
      default:       b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ilv_pos_track.sv
// Tracks the position inside the round-robin chunk pattern with an offset
// counter and a slot counter, so no division is needed.
module ilv_pos_track #(
  parameter int CHUNK_BYTES = 288,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] count_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic             keep_o,
  output logic [IDX_W-1:0] slot_o
);

  localparam int OFF_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(CHUNK_BYTES - 1);

  logic [OFF_W-1:0] off_q;
  logic [IDX_W-1:0] slot_q;
  logic [IDX_W-1:0] slot_last;
  logic [IDX_W-1:0] sel_slot;

  assign slot_last = IDX_W'(count_i - 1'b1);
  assign sel_slot  = IDX_W'(sel_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      off_q  <= '0;
      slot_q <= '0;
    end else if (step_i) begin
      if (off_q == OFF_LAST) begin
        off_q  <= '0;
        slot_q <= (slot_q == slot_last) ? '0 : IDX_W'(slot_q + 1'b1);
      end else begin
        off_q <= OFF_W'(off_q + 1'b1);
      end
    end
  end

  assign keep_o = (sel_i != '0) && (sel_i <= count_i) && (slot_q == sel_slot);
  assign slot_o = slot_q;

endmodule

// File: rtl/ilv_sig_check.sv
// Compares the first SIG_LEN kept bytes against the fixed signature, one
// byte per accepted transfer, without buffering them.
module ilv_sig_check #(
  parameter int SIG_LEN = ilv_pkg::SIG_LEN,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic              ok_o
);

  localparam int IW = $clog2(SIG_LEN + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(SIG_LEN - 1);

  logic [IW-1:0] idx_q;
  logic          bad_q;
  logic          done_q;
  logic          ok_q;
  logic          mism;

  assign mism = (data_i != DATA_W'(ilv_pkg::sig_byte(int'(idx_q))));

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      idx_q  <= '0;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (fire_i && !done_q) begin
      idx_q <= IW'(idx_q + 1'b1);
      if (mism) bad_q <= 1'b1;
      if (idx_q == IDX_LAST) begin
        done_q <= 1'b1;
        ok_q   <= !(bad_q || mism);
      end
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;

endmodule

// File: rtl/ilv_out_reg.sv
// Single registered output slot with valid/ready.
module ilv_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              space_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign space_o = !valid_q || ready_i;

endmodule

// File: rtl/ilv_image_sel.sv
module ilv_image_sel #(
  parameter int CHUNK_BYTES = 288,
  parameter int MAX_IMAGES  = 4,
  parameter int DATA_W      = 8,
  parameter int IDX_W       = $clog2(MAX_IMAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic [IDX_W-1:0]  img_sel_i,
  input  logic [IDX_W-1:0]  img_count_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              hdr_done_o,
  output logic              hdr_ok_o
);

  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] sel_q;
  logic [IDX_W-1:0] count_q;
  logic             keep_w;
  logic [IDX_W-1:0] slot_w;
  logic             space_w;
  logic             accept_w;
  logic             load_w;

  // configuration captured only at restart
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= ONE;
      count_q <= ONE;
    end else if (restart_i) begin
      sel_q   <= img_sel_i;
      count_q <= (img_count_i == '0) ? ONE : img_count_i;
    end
  end

  ilv_pos_track #(
    .CHUNK_BYTES (CHUNK_BYTES),
    .IDX_W       (IDX_W)
  ) pos_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart_i),
    .step_i    (accept_w),
    .count_i   (count_q),
    .sel_i     (sel_q),
    .keep_o    (keep_w),
    .slot_o    (slot_w)
  );

  assign in_ready_o = !restart_i && (!keep_w || space_w);
  assign accept_w   = in_valid_i && in_ready_o;
  assign load_w     = accept_w && keep_w;

  ilv_out_reg #(
    .DATA_W (DATA_W)
  ) out_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart_i),
    .load_i    (load_w),
    .data_i    (in_data_i),
    .ready_i   (out_ready_i),
    .valid_o   (out_valid_o),
    .data_o    (out_data_o),
    .space_o   (space_w)
  );

  ilv_sig_check #(
    .SIG_LEN (ilv_pkg::SIG_LEN),
    .DATA_W  (DATA_W)
  ) sig_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart_i),
    .fire_i    (load_w),
    .data_i    (in_data_i),
    .done_o    (hdr_done_o),
    .ok_o      (hdr_ok_o)
  );

endmodule

// File: rtl/ilv_image_sel_chk.sv
module ilv_image_sel_chk #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              restart_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic              hdr_done_o,
  input logic              hdr_ok_o,
  input logic              keep_w,
  input logic [IDX_W-1:0]  slot_w,
  input logic [IDX_W-1:0]  sel_q,
  input logic [IDX_W-1:0]  count_q
);

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
    slot_w < count_q); // R1

  AST_SKIP_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (!restart_i && !keep_w) |-> in_ready_o); // R3

  AST_RESTART_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    restart_i |-> !in_ready_o); // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (!out_valid_o && !hdr_done_o && !hdr_ok_o)); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !restart_i |=> ($stable(sel_q) && $stable(count_q))); // R5

  AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    hdr_ok_o |-> hdr_done_o); // R6

  AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (hdr_done_o && !restart_i) |=> (hdr_done_o && $stable(hdr_ok_o))); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i && !restart_i) |=> (out_valid_o && $stable(out_data_o))); // R8

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    count_q != '0); // R9

endmodule

bind ilv_image_sel ilv_image_sel_chk #(
  .IDX_W  (IDX_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .restart_i   (restart_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i),
  .hdr_done_o  (hdr_done_o),
  .hdr_ok_o    (hdr_ok_o),
  .keep_w      (keep_w),
  .slot_w      (slot_w),
  .sel_q       (sel_q),
  .count_q     (count_q)
);

// File: tb/ilv_image_sel_tb_top.sv
`timescale 1ns/1ps
module ilv_image_sel_tb_top;

  localparam int CH    = 288;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             restart = 1'b0;
  logic [IDX_W-1:0] img_sel = '0;
  logic [IDX_W-1:0] img_count = '0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = '0;
  logic             in_ready;
  logic             out_valid;
  logic [7:0]       out_data;
  logic             out_ready = 1'b0;
  logic             hdr_done;
  logic             hdr_ok;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  ilv_image_sel #(
    .CHUNK_BYTES (CH),
    .MAX_IMAGES  (4),
    .DATA_W      (8)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .restart_i   (restart),
    .img_sel_i   (img_sel),
    .img_count_i (img_count),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .out_ready_i (out_ready),
    .hdr_done_o  (hdr_done),
    .hdr_ok_o    (hdr_ok)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // signature bytes, written from the requirement R6
  function automatic logic [7:0] sig_b(input int i);
    logic [7:0] t [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                           8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    return t[i];
  endfunction

  function automatic int eff_count(input int cnt);
    return (cnt == 0) ? 1 : cnt;
  endfunction

  // R1 model: which image a stream byte belongs to (0-based)
  function automatic int img_of(input int n, input int eff);
    return (n / CH) % eff;
  endfunction

  function automatic bit keep_at(input int n, input int eff, input int sel);
    return (sel >= 1) && (sel <= eff) && (img_of(n, eff) == sel - 1);
  endfunction

  function automatic logic [7:0] gen_byte(input int n, input int eff,
                                          input int sel, input int corrupt);
    int img = img_of(n, eff);
    int p   = (n / CH / eff) * CH + (n % CH);
    logic [7:0] b;
    if (p < 13) b = sig_b(p);
    else        b = 8'((img * 37 + p * 5 + 3) & 255);
    if ((img == sel - 1) && (p == corrupt)) b = b ^ 8'h55;
    return b;
  endfunction

  task automatic do_restart(input int sel, input int cnt);
    @(negedge clk);
    in_valid  = 1'b0;
    restart   = 1'b1;
    img_sel   = IDX_W'(sel);
    img_count = IDX_W'(cnt);
    @(negedge clk);
    restart = 1'b0;
  endtask

  // Drives nbytes of the combined stream and checks the output against the model.
  task automatic run_stream(input bit do_rs, input int cnt, input int sel,
                            input int nbytes, input int corrupt, input int stall_mod,
                            input int chg_at,
                            output int got, output int bad, output int stall_skip,
                            output int hdr_err, output int first_ok);
    logic [7:0] exp_q [$];
    int eff = eff_count(cnt);
    int idx = 0;
    int kept_in = 0;
    int cyc = 0;
    bit seen_done = 0;
    got = 0; bad = 0; stall_skip = 0; hdr_err = 0; first_ok = -1;
    if (do_rs) do_restart(sel, cnt);
    while ((idx < nbytes) || out_valid) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++;
        break;
      end
      out_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) == 0);
      if (idx == chg_at) img_sel = IDX_W'(sel + 1);
      if (idx < nbytes) begin
        in_valid = 1'b1;
        in_data  = gen_byte(idx, eff, sel, corrupt);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (hdr_done !== (kept_in >= 13)) hdr_err++;
      if (hdr_done === 1'b1) begin
        if (!seen_done) begin
          seen_done = 1;
          first_ok = int'(hdr_ok);
        end else if (int'(hdr_ok) != first_ok) begin
          hdr_err++;
        end
      end
      if (in_valid && (idx < nbytes) && !keep_at(idx, eff, sel) && !in_ready) stall_skip++;
      if (out_valid && out_ready) begin
        got++;
        if (exp_q.size() == 0) bad++;
        else if (out_data !== exp_q.pop_front()) bad++;
      end
      if (in_valid && in_ready) begin
        if (keep_at(idx, eff, sel)) begin
          exp_q.push_back(in_data);
          kept_in++;
        end
        idx++;
      end
    end
    in_valid = 1'b0;
    bad += exp_q.size();
  endtask

  task automatic t_reset();
    #1;
    check(out_valid === 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    check(hdr_done === 1'b0, "R10", "hdr_done after reset", int'(hdr_done), 0);
    check(hdr_ok === 1'b0, "R10", "hdr_ok after reset", int'(hdr_ok), 0);
  endtask

  task automatic t_defaults();
    int got, bad, ss, he, fo;
    run_stream(0, 1, 1, 40, -1, 0, -1, got, bad, ss, he, fo);
    check(got == 40, "R5", "bytes out with reset configuration", got, 40);
    check(bad == 0, "R5", "data errors with reset configuration", bad, 0);
  endtask

  task automatic t_three_images();
    int got, bad, ss, he, fo;
    run_stream(1, 3, 2, 3 * CH * 2, -1, 0, -1, got, bad, ss, he, fo);
    check(got == 2 * CH, "R1", "bytes of image 2 of 3", got, 2 * CH);
    check(bad == 0, "R2", "data errors image 2 of 3", bad, 0);
    check(ss == 0, "R3", "stalls on skipped bytes", ss, 0);
    check(he == 0, "R6", "flag timing errors", he, 0);
    check(hdr_ok === 1'b1, "R6", "hdr_ok on good signature", int'(hdr_ok), 1);
    repeat (3) @(negedge clk);
    check(hdr_done === 1'b1 && hdr_ok === 1'b1, "R7", "flags held while idle",
          int'(hdr_ok), 1);
  endtask

  task automatic t_backpressure();
    int got, bad, ss, he, fo;
    run_stream(1, 2, 1, 2 * CH * 2 + 50, -1, 3, -1, got, bad, ss, he, fo);
    check(got == 2 * CH + 50, "R8", "bytes out under backpressure", got, 2 * CH + 50);
    check(bad == 0, "R8", "data errors under backpressure", bad, 0);
    check(ss == 0, "R3", "stalls on skipped bytes with out_ready low", ss, 0);
  endtask

  task automatic t_bad_sig();
    int got, bad, ss, he, fo;
    run_stream(1, 3, 3, 3 * CH, 12, 0, -1, got, bad, ss, he, fo);
    check(hdr_done === 1'b1, "R6", "hdr_done with bad signature", int'(hdr_done), 1);
    check(hdr_ok === 1'b0, "R6", "hdr_ok with bad last byte", int'(hdr_ok), 0);
    check(he == 0, "R7", "flag timing or stability errors", he, 0);
    check(bad == 0 && got == CH, "R2", "image 3 of 3 bytes", got, CH);
  endtask

  task automatic t_sel_change();
    int got, bad, ss, he, fo;
    run_stream(1, 2, 1, 2 * CH * 2, -1, 0, 100, got, bad, ss, he, fo);
    check(got == 2 * CH, "R5", "bytes out after img_sel change", got, 2 * CH);
    check(bad == 0, "R5", "data errors after img_sel change", bad, 0);
  endtask

  task automatic t_out_of_range();
    int got, bad, ss, he, fo;
    run_stream(1, 2, 0, 2 * CH, -1, 0, -1, got, bad, ss, he, fo);
    check(got == 0 && bad == 0, "R9", "output with image 0", got, 0);
    check(ss == 0, "R9", "stalls with image 0", ss, 0);
    check(hdr_done === 1'b0, "R9", "hdr_done with image 0", int'(hdr_done), 0);
    run_stream(1, 2, 3, 2 * CH, -1, 0, -1, got, bad, ss, he, fo);
    check(got == 0 && bad == 0, "R9", "output with image above count", got, 0);
  endtask

  task automatic t_count_zero();
    int got, bad, ss, he, fo;
    run_stream(1, 0, 1, 600, -1, 0, -1, got, bad, ss, he, fo);
    check(got == 600, "R9", "count 0 acts as 1", got, 600);
    check(bad == 0 && hdr_ok === 1'b1, "R9", "data with count 0", bad, 0);
  endtask

  task automatic t_restart_collision();
    int got, bad, ss, he, fo;
    do_restart(1, 1);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      in_valid  = 1'b1;
      in_data   = (i < 13) ? sig_b(i) : 8'hA5;
    end
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = 8'h3C;
    @(negedge clk);
    in_data = 8'h3D;
    #1;
    check(out_valid === 1'b1 && in_ready === 1'b0, "R8", "stall with full output",
          int'(in_ready), 0);
    check(hdr_done === 1'b1 && hdr_ok === 1'b1, "R7", "flags before restart",
          int'(hdr_ok), 1);
    @(negedge clk);
    restart = 1'b1;
    img_sel = IDX_W'(1);
    img_count = IDX_W'(1);
    #1;
    check(in_ready === 1'b0, "R4", "in_ready during restart", int'(in_ready), 0);
    @(negedge clk);
    restart  = 1'b0;
    in_valid = 1'b0;
    #1;
    check(out_valid === 1'b0, "R4", "out_valid after restart", int'(out_valid), 0);
    check(hdr_done === 1'b0 && hdr_ok === 1'b0, "R4", "flags after restart",
          int'(hdr_done), 0);
    run_stream(1, 2, 2, 2 * CH, -1, 0, -1, got, bad, ss, he, fo);
    check(got == CH && bad == 0, "R4", "aligned stream after restart", got, CH);
    check(hdr_ok === 1'b1, "R4", "signature after restart", int'(hdr_ok), 1);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_defaults();
    t_three_images();
    t_backpressure();
    t_bad_sig();
    t_sel_change();
    t_out_of_range();
    t_count_zero();
    t_restart_collision();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule